// File: doc/BRIEF.md
# Monitor Conversion Control with Shutdown

This block holds the configuration byte that steers the measurement front end of a multi-channel hardware monitor. It tells the converter which channel to measure next. The converter either cycles through every valid channel in turn or stays on a single channel, whose code comes from bits [7:5] of a separate register and is presented on `chan_code_in`. It also tells the converter whether each reading is averaged over many conversions or taken from a single conversion. Averaging is on by default, and turning it off makes each channel finish much sooner.

Setting the shutdown bit stops all conversions. It also drives every fan PWM output to its off level: low for a normal output and high for an inverted one. While shutdown is set, the current duty-cycle readback of every output returns zero. When an external lock input is high, the configuration byte cannot be written.

The converter, the averaging arithmetic and the PWM generators sit outside this block. They connect through a start/done handshake, raw PWM inputs and duty inputs.

Top module: `mon_conv_ctrl`

## Requirements
- R1: After reset the configuration byte reads 0x00: channels are visited in turn, averaging is on (`avg_en` = 1) and shutdown is off.
- R2: Only bits 7 (shutdown), 6 (single channel) and 4 (averaging off) hold data. Bit 5 and bits [3:0] always read 0, and writing 1 to them has no effect.
- R3: While `lock_in` is 1, a write leaves the configuration byte and every output it controls unchanged.
- R4: With bit 4 at 0, `avg_en` is 1 and each channel takes 16 start/done handshakes. With bit 4 at 1, `avg_en` is 0 and each channel takes one handshake.
- R5: With bit 6 at 0, channels are converted in ascending code order over the valid codes 001, 010, 101, 110 and 111, wrapping from 111 back to 001.
- R6: With bit 6 at 1 and a valid code on `chan_code_in`, every conversion start carries that code.
- R7: With bit 6 at 1 and a reserved code (000, 011 or 100) on `chan_code_in`, no conversion is started and `busy` stays 0. `conv_start` never carries a reserved code.
- R8: While bit 7 is 1, each `pwm_out` bit equals the matching `pwm_inv` bit. Otherwise it follows `pwm_raw_in`.
- R9: While bit 7 is 1, `duty_rd` reads all zeros. Otherwise it equals `duty_in`.
- R10: While bit 7 is 1, no conversion is started and `busy` is 0. After bit 7 is cleared, PWM and duty readback follow their inputs from the next clock, and the first channel converted is code 001.
- R11: `conv_start` is a one-cycle pulse, is never high on two consecutive cycles, and is high only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the configuration byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Configuration byte readback |
| lock_in | input | 1 | Write lock, 1 makes the byte read-only |
| chan_code_in | input | 3 | Channel code for single-channel mode |
| conv_start | output | 1 | Conversion start pulse |
| conv_chan | output | 3 | Channel code of the current conversion |
| conv_done | input | 1 | Conversion complete from the converter |
| avg_en | output | 1 | Averaging enable to the converter |
| busy | output | 1 | A channel conversion is in progress |
| pwm_raw_in | input | NUM_PWM | PWM outputs from the generators |
| pwm_inv | input | NUM_PWM | Per-output invert setting |
| pwm_out | output | NUM_PWM | Gated PWM outputs |
| duty_in | input | NUM_PWM*8 | Current duty of each output |
| duty_rd | output | NUM_PWM*8 | Duty readback, zero in shutdown |

## Verification
The hardest case to reach is a restart of the sequence in the middle of a round. Shutdown has to arrive after the sequencer has moved past the first channel, possibly while a handshake is still outstanding. The bench runs round-robin without averaging and watches its conversion log until the third channel has started. Only then does it set shutdown. It waits for the stale done to drain, clears shutdown, and checks that the next start carries code 001 rather than the code that would have come next.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
   localparam int CHAN_W    = 3;
   localparam int NUM_CODES = 1 << CHAN_W;
   localparam int CFG_W     = 8;

   localparam int BIT_SHDN   = 7;
   localparam int BIT_SINGLE = 6;
   localparam int BIT_NOAVG  = 4;
   localparam logic [CFG_W-1:0] CFG_WR_MASK = 8'hD0;

   typedef logic [CHAN_W-1:0] chan_t;
   typedef enum logic [1:0] {SEQ_IDLE, SEQ_REQ, SEQ_WAIT} seq_state_t;

   function automatic chan_t first_code(input logic [NUM_CODES-1:0] mask);
      chan_t res;
      res = '0;
      for (int i = NUM_CODES - 1; i >= 0; i--) begin
         if (mask[i]) res = chan_t'(i);
      end
      return res;
   endfunction

   function automatic chan_t next_code(input chan_t c, input logic [NUM_CODES-1:0] mask);
      chan_t res;
      chan_t idx;
      logic  found;
      res   = c;
      found = 1'b0;
      for (int k = 1; k <= NUM_CODES; k++) begin
         idx = chan_t'(int'(c) + k);
         if (!found && mask[idx]) begin
            res   = idx;
            found = 1'b1;
         end
      end
      return res;
   endfunction
endpackage

// File: rtl/mcc_cfg_reg.sv
module mcc_cfg_reg
   import mcc_pkg::*;
#(
   parameter int                CFG_BITS = CFG_W,
   parameter logic [CFG_W-1:0]  WR_MASK  = CFG_WR_MASK
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                lock,
   input  logic [CFG_BITS-1:0] wdata,
   output logic [CFG_BITS-1:0] cfg_q
);
   if (CFG_BITS != CFG_W) begin : g_bad_width
      $error("mcc_cfg_reg: CFG_BITS must equal the package width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en && !lock) begin
         cfg_q <= wdata & WR_MASK;
      end
   end
endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
   import mcc_pkg::*;
#(
   parameter int                   AVG_COUNT  = 16,
   parameter logic [NUM_CODES-1:0] CHAN_VALID = 8'b1110_0110
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  shdn,
   input  logic  single,
   input  logic  no_avg,
   input  chan_t sel_code,
   input  logic  done,
   output logic  start,
   output chan_t chan,
   output logic  busy
);
   localparam int CNT_W = (AVG_COUNT > 1) ? $clog2(AVG_COUNT) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(AVG_COUNT - 1);
   localparam chan_t FIRST = first_code(CHAN_VALID);

   if (AVG_COUNT < 2) begin : g_bad_avg
      $error("mcc_seq: AVG_COUNT must be at least 2");
   end
   if (CHAN_VALID == '0) begin : g_bad_mask
      $error("mcc_seq: CHAN_VALID needs at least one valid code");
   end

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;
   chan_t            cur;
   chan_t            rr_code;
   logic             last_hs;

   assign last_hs = no_avg || (cnt == CNT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         cnt     <= '0;
         cur     <= FIRST;
         rr_code <= FIRST;
      end else if (shdn) begin
         state   <= SEQ_IDLE;
         cnt     <= '0;
         rr_code <= FIRST;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               cnt <= '0;
               if (single) begin
                  if (CHAN_VALID[sel_code]) begin
                     cur   <= sel_code;
                     state <= SEQ_REQ;
                  end
               end else begin
                  cur   <= rr_code;
                  state <= SEQ_REQ;
               end
            end
            SEQ_REQ: state <= SEQ_WAIT;
            SEQ_WAIT: begin
               if (done) begin
                  if (last_hs) begin
                     state <= SEQ_IDLE;
                     cnt   <= '0;
                     if (!single) rr_code <= next_code(cur, CHAN_VALID);
                  end else begin
                     cnt   <= cnt + 1'b1;
                     state <= SEQ_REQ;
                  end
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign start = (state == SEQ_REQ) && !shdn;
   assign busy  = (state != SEQ_IDLE) && !shdn;
   assign chan  = cur;
endmodule

// File: rtl/mcc_pwm_gate.sv
module mcc_pwm_gate #(
   parameter int NUM_PWM = 3,
   parameter int DUTY_W  = 8
) (
   input  logic                      shdn,
   input  logic [NUM_PWM-1:0]        raw,
   input  logic [NUM_PWM-1:0]        inv,
   input  logic [NUM_PWM*DUTY_W-1:0] duty_in,
   output logic [NUM_PWM-1:0]        pwm,
   output logic [NUM_PWM*DUTY_W-1:0] duty_rd
);
   if (NUM_PWM < 1) begin : g_bad_num
      $error("mcc_pwm_gate: NUM_PWM must be at least 1");
   end

   for (genvar i = 0; i < NUM_PWM; i++) begin : g_out
      assign pwm[i] = shdn ? inv[i] : raw[i];
      assign duty_rd[i*DUTY_W +: DUTY_W] = shdn ? '0 : duty_in[i*DUTY_W +: DUTY_W];
   end
endmodule

// File: rtl/mon_conv_ctrl.sv
module mon_conv_ctrl
   import mcc_pkg::*;
#(
   parameter int                   NUM_PWM    = 3,
   parameter int                   DUTY_W     = 8,
   parameter int                   AVG_COUNT  = 16,
   parameter logic [NUM_CODES-1:0] CHAN_VALID = 8'b1110_0110
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [7:0]                reg_wdata,
   output logic [7:0]                reg_rdata,
   input  logic                      lock_in,
   input  logic [2:0]                chan_code_in,
   output logic                      conv_start,
   output logic [2:0]                conv_chan,
   input  logic                      conv_done,
   output logic                      avg_en,
   output logic                      busy,
   input  logic [NUM_PWM-1:0]        pwm_raw_in,
   input  logic [NUM_PWM-1:0]        pwm_inv,
   output logic [NUM_PWM-1:0]        pwm_out,
   input  logic [NUM_PWM*DUTY_W-1:0] duty_in,
   output logic [NUM_PWM*DUTY_W-1:0] duty_rd
);
   logic [CFG_W-1:0] cfg;
   logic             shdn;

   mcc_cfg_reg #(.CFG_BITS(CFG_W), .WR_MASK(CFG_WR_MASK)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr),
      .lock  (lock_in),
      .wdata (reg_wdata),
      .cfg_q (cfg)
   );

   assign shdn      = cfg[BIT_SHDN];
   assign reg_rdata = cfg;
   assign avg_en    = !cfg[BIT_NOAVG];

   mcc_seq #(.AVG_COUNT(AVG_COUNT), .CHAN_VALID(CHAN_VALID)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .shdn     (shdn),
      .single   (cfg[BIT_SINGLE]),
      .no_avg   (cfg[BIT_NOAVG]),
      .sel_code (chan_code_in),
      .done     (conv_done),
      .start    (conv_start),
      .chan     (conv_chan),
      .busy     (busy)
   );

   mcc_pwm_gate #(.NUM_PWM(NUM_PWM), .DUTY_W(DUTY_W)) u_pwm (
      .shdn    (shdn),
      .raw     (pwm_raw_in),
      .inv     (pwm_inv),
      .duty_in (duty_in),
      .pwm     (pwm_out),
      .duty_rd (duty_rd)
   );
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
   parameter int       NUM_PWM    = 3,
   parameter int       DUTY_W     = 8,
   parameter bit [7:0] CHAN_VALID = 8'b1110_0110
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      reg_wr,
   input logic [7:0]                reg_rdata,
   input logic                      lock_in,
   input logic                      conv_start,
   input logic [2:0]                conv_chan,
   input logic                      avg_en,
   input logic                      busy,
   input logic [NUM_PWM-1:0]        pwm_raw_in,
   input logic [NUM_PWM-1:0]        pwm_inv,
   input logic [NUM_PWM-1:0]        pwm_out,
   input logic [NUM_PWM*DUTY_W-1:0] duty_in,
   input logic [NUM_PWM*DUTY_W-1:0] duty_rd
);
   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[5] == 1'b0) && (reg_rdata[3:0] == 4'h0));

   assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && lock_in) |=> (reg_rdata == $past(reg_rdata)));

   assert_avg_follows_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      avg_en == !reg_rdata[4]);

   assert_valid_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> CHAN_VALID[conv_chan]);

   assert_pwm_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[7] |-> (pwm_out == pwm_inv));

   assert_pwm_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[7] |-> (pwm_out == pwm_raw_in));

   assert_duty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[7] |-> (duty_rd == '0));

   assert_duty_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[7] |-> (duty_rd == duty_in));

   assert_shdn_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[7] |-> (!conv_start && !busy));

   assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);
endmodule

bind mon_conv_ctrl mcc_checker #(
   .NUM_PWM    (NUM_PWM),
   .DUTY_W     (DUTY_W),
   .CHAN_VALID (CHAN_VALID)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rdata  (reg_rdata),
   .lock_in    (lock_in),
   .conv_start (conv_start),
   .conv_chan  (conv_chan),
   .avg_en     (avg_en),
   .busy       (busy),
   .pwm_raw_in (pwm_raw_in),
   .pwm_inv    (pwm_inv),
   .pwm_out    (pwm_out),
   .duty_in    (duty_in),
   .duty_rd    (duty_rd)
);

// File: tb/mon_conv_ctrl_test.sv
module mon_conv_ctrl_test;
   localparam int NP = 3;
   localparam int DW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr = 1'b0;
   logic [7:0]      reg_wdata = '0;
   logic [7:0]      reg_rdata;
   logic            lock_in = 1'b0;
   logic [2:0]      chan_code_in = 3'd0;
   logic            conv_start;
   logic [2:0]      conv_chan;
   logic            conv_done = 1'b0;
   logic            avg_en;
   logic            busy;
   logic [NP-1:0]   pwm_raw_in = '0;
   logic [NP-1:0]   pwm_inv = '0;
   logic [NP-1:0]   pwm_out;
   logic [NP*DW-1:0] duty_in = '0;
   logic [NP*DW-1:0] duty_rd;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int log_chan [0:1023];
   int log_n = 0;
   int dly = 0;

   always #4 clk = ~clk;

   mon_conv_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .lock_in(lock_in), .chan_code_in(chan_code_in),
      .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
      .avg_en(avg_en), .busy(busy), .pwm_raw_in(pwm_raw_in), .pwm_inv(pwm_inv),
      .pwm_out(pwm_out), .duty_in(duty_in), .duty_rd(duty_rd)
   );

   // converter model: logs each start, answers with done a few cycles later
   always @(negedge clk) begin
      conv_done <= 1'b0;
      if (conv_start) begin
         if (log_n < 1024) log_chan[log_n] <= int'(conv_chan);
         if (log_n < 1024) log_n <= log_n + 1;
         dly <= 2;
      end else if (dly == 1) begin
         conv_done <= 1'b1;
         dly <= 0;
      end else if (dly > 1) begin
         dly <= dly - 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      check(reg_rdata == 8'h00, "R1 reset cfg", reg_rdata, 0);
      check(avg_en == 1'b1, "R1 reset avg_en", avg_en, 1);
      check(pwm_out == pwm_raw_in, "R1 reset pwm", pwm_out, pwm_raw_in);
      check(duty_rd == duty_in, "R1 reset duty", duty_rd, duty_in);
   endtask

   task automatic t_reserved_bits;
      write_cfg(8'h80);
      write_cfg(8'h2F | 8'h80);
      check(reg_rdata == 8'h80, "R2 reserved ignored", reg_rdata, 8'h80);
      write_cfg(8'hFF);
      check(reg_rdata == 8'hD0, "R2 data bits only", reg_rdata, 8'hD0);
      write_cfg(8'h80);
   endtask

   task automatic t_round_robin;
      int base;
      int exp_seq [6] = '{1, 2, 5, 6, 7, 1};
      write_cfg(8'h80);
      idle(6);
      base = log_n;
      write_cfg(8'h10);
      check(avg_en == 1'b0, "R4 avg_en off", avg_en, 0);
      idle(60);
      check(log_n - base >= 6, "R5 start count", log_n - base, 6);
      for (int i = 0; i < 6; i++)
         check(log_chan[base + i] == exp_seq[i], "R5 order", log_chan[base + i], exp_seq[i]);
   endtask

   task automatic t_averaging;
      int base;
      write_cfg(8'h80);
      idle(6);
      base = log_n;
      write_cfg(8'h00);
      check(avg_en == 1'b1, "R4 avg_en on", avg_en, 1);
      idle(120);
      check(log_n - base >= 17, "R4 avg start count", log_n - base, 17);
      for (int i = 0; i < 16; i++)
         check(log_chan[base + i] == 1, "R4 sixteen per channel", log_chan[base + i], 1);
      check(log_chan[base + 16] == 2, "R4 next channel after 16", log_chan[base + 16], 2);
   endtask

   task automatic t_single_valid;
      int base;
      write_cfg(8'h80);
      idle(6);
      chan_code_in = 3'd6;
      base = log_n;
      write_cfg(8'h50);
      idle(40);
      check(log_n - base >= 3, "R6 single starts", log_n - base, 3);
      for (int i = 0; i < 3; i++)
         check(log_chan[base + i] == 6, "R6 single code", log_chan[base + i], 6);
   endtask

   task automatic t_single_reserved;
      int base;
      bit busy_seen;
      int codes [3] = '{0, 3, 4};
      for (int c = 0; c < 3; c++) begin
         write_cfg(8'h80);
         idle(6);
         chan_code_in = 3'(codes[c]);
         base = log_n;
         busy_seen = 1'b0;
         write_cfg(8'h50);
         for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (busy) busy_seen = 1'b1;
         end
         check(log_n == base, "R7 no start on reserved code", log_n - base, 0);
         check(!busy_seen, "R7 busy low on reserved code", busy_seen, 0);
      end
   endtask

   task automatic t_shutdown;
      int base;
      bit busy_seen;
      write_cfg(8'h10);
      idle(10);
      pwm_raw_in = 3'b101;
      duty_in = 24'hA5_3C_FF;
      pwm_inv = 3'b010;
      base = log_n;
      busy_seen = 1'b0;
      write_cfg(8'h80);
      check(pwm_out == 3'b010, "R8 pwm off level", pwm_out, 3'b010);
      check(duty_rd == '0, "R9 duty zero", duty_rd, 0);
      base = log_n;
      pwm_inv = 3'b101;
      pwm_raw_in = 3'b010;
      @(negedge clk);
      check(pwm_out == 3'b101, "R8 pwm inverted off level", pwm_out, 3'b101);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (busy) busy_seen = 1'b1;
      end
      check(log_n == base, "R10 no start in shutdown", log_n - base, 0);
      check(!busy_seen, "R10 busy low in shutdown", busy_seen, 0);
      write_cfg(8'h10);
      check(pwm_out == pwm_raw_in, "R10 pwm restored", pwm_out, pwm_raw_in);
      check(duty_rd == duty_in, "R10 duty restored", duty_rd, duty_in);
   endtask

   task automatic t_restart;
      int base;
      int guard;
      write_cfg(8'h80);
      idle(6);
      base = log_n;
      write_cfg(8'h10);
      guard = 0;
      while ((log_n - base) < 3 && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      check(log_chan[base + 2] == 5, "R5 third channel", log_chan[base + 2], 5);
      write_cfg(8'h80);
      idle(8);
      base = log_n;
      write_cfg(8'h10);
      idle(20);
      check(log_n > base, "R10 restarts after shutdown", log_n - base, 1);
      check(log_chan[base] == 1, "R10 restart at first code", log_chan[base], 1);
   endtask

   task automatic t_lock;
      write_cfg(8'h10);
      pwm_raw_in = 3'b011;
      pwm_inv = 3'b100;
      lock_in = 1'b1;
      write_cfg(8'h80);
      check(reg_rdata == 8'h10, "R3 locked cfg", reg_rdata, 8'h10);
      check(pwm_out == 3'b011, "R3 locked pwm", pwm_out, 3'b011);
      check(avg_en == 1'b0, "R3 locked avg_en", avg_en, 0);
      lock_in = 1'b0;
      write_cfg(8'h00);
      check(reg_rdata == 8'h00, "R3 unlocked write", reg_rdata, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reserved_bits();
      t_round_robin();
      t_averaging();
      t_single_valid();
      t_single_reserved();
      t_shutdown();
      t_restart();
      t_lock();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule